// File: doc/BRIEF.md
# Region Chip-Select Decoder with Per-Region Bus Sizing

This block connects a CPU-side halfword bus to an external asynchronous-style device bus. The top three bits of the byte address pick one of seven fixed regions. Each region has its own active-low chip-select line. A region that holds a single device can therefore drive that device's select pin directly, with no address decoder outside the block.

Each region holds two configuration bits, loaded through a small write port:
- a width bit, which selects an 8-bit or a 16-bit data path;
- a device-type bit, which is presented on `ext_io` while the region is being accessed.

In a 16-bit region, an access is one external cycle with the byte enables passed straight through. In an 8-bit region, the byte lanes are serialised onto data lane 0. A two-byte access becomes two consecutive external cycles: the even byte address first, then the odd one. The first read byte is held internally until the second byte arrives, and the CPU receives one reassembled halfword together with a single ready pulse.

The CPU holds `cpu_req` and the request fields steady until `cpu_ready` pulses. Each external cycle lasts exactly one clock, and the external device must return read data within that cycle.

Top module: `csdec_top`

## Requirements
- R1: The region number is byte-address bits [23:21], which is `cpu_hw_addr[23:21]`. During every external cycle of an access to region n (n from 0 to 6), exactly one select line is low, and it is `ext_cs_n[n]`. Whenever no external cycle is running, all select lines are high, including the cycle in which `cpu_ready` is high.
- R2: After reset, all select lines, `ext_rd_n` and `ext_wr_n` are high, and `cpu_ready` and `ext_io` are 0. Every region starts as 16-bit wide with type bit 0.
- R3: When `cfg_we` is high at a rising edge and `cfg_sel` is below 7, the edge stores `cfg_narrow` (1 = 8-bit) and `cfg_io` into region `cfg_sel`. The new values apply to every access accepted after that edge.
- R4: During an external cycle, `ext_io` equals the type bit of the addressed region. It is 0 at all other times.
- R5: An access to a 16-bit region makes one external cycle in the clock after acceptance. In that cycle:
  - `ext_addr` is the byte address with bit 0 cleared;
  - `ext_be_n` is the inverse of `cpu_be` (bit 0 = low byte);
  - `ext_wdata` equals `cpu_wdata`.
  
  `cpu_ready` follows one clock later. For a read, `cpu_rdata` then equals the `ext_rdata` value seen during the cycle.
- R6: An access to an 8-bit region with `cpu_be` = 11 makes two back-to-back external cycles. The first is at the even byte address and carries `cpu_wdata[7:0]`. The second is at the even address plus one and carries `cpu_wdata[15:8]`. In both cycles the data uses `ext_wdata[7:0]` with `ext_wdata[15:8]` at 0, and `ext_be_n` is 10. `cpu_ready` comes one clock after the second cycle. For a read, `cpu_rdata` is {second `ext_rdata[7:0]`, first `ext_rdata[7:0]`}.
- R7: An access to an 8-bit region with a single byte enabled makes one external cycle.
  - `cpu_be` = 01 uses the even address and `cpu_wdata[7:0]`.
  - `cpu_be` = 10 uses the odd address and `cpu_wdata[15:8]`.
  
  The data is on lane 0, and a read result lands in the matching half of `cpu_rdata`, with the other half 0.
- R8: Every accepted request produces exactly one `cpu_ready` pulse, one clock long. During an external cycle, `ext_rd_n` is low for reads and `ext_wr_n` is low for writes, never both.
- R9: An access to region 7, or one with `cpu_be` = 00, makes no external cycle. `cpu_ready` pulses in the clock after acceptance, with `cpu_rdata` = 0. `cpu_rdata` is also 0 after every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Region to configure |
| cfg_narrow | input | 1 | Width bit to store, 1 = 8-bit |
| cfg_io | input | 1 | Device-type bit to store |
| cpu_req | input | 1 | Request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_hw_addr | input | 23 | Halfword address (byte address bits 23:1) |
| cpu_be | input | 2 | Byte enables, bit 0 = low byte |
| cpu_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | One-clock completion pulse |
| cpu_rdata | output | 16 | Read data, valid with ready |
| ext_addr | output | 24 | External byte address |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_be_n | output | 2 | External byte enables, active low |
| ext_cs_n | output | 7 | Per-region chip-selects, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_io | output | 1 | Type bit of the selected region |

## Verification
Some properties are checked by assertions on every clock:
- at most one chip-select is active at a time;
- the strobes are exclusive during a cycle and quiet outside it;
- every ready pulse is one clock long with all selects released;
- the second byte cycle of a split access advances the address by one while keeping the same select.

Other behaviour can only be shown by the bench's scenarios, because it depends on the configuration history:
- the exact cycle count for each width and byte-enable pattern;
- the lane steering of write bytes;
- the reassembly order of split reads;
- the type bit;
- a configuration change taking effect on the next access.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned HALF_W = 2 * BYTE_W;
   localparam int unsigned LANES  = HALF_W / BYTE_W;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PH1  = 2'd1,
      ST_PH2  = 2'd2,
      ST_DONE = 2'd3
   } seq_st_e;
endpackage

// File: rtl/csdec_cfg.sv
module csdec_cfg #(
   parameter int unsigned NUM_REGIONS = 7,
   parameter int unsigned SEL_W = 3,
   parameter logic [NUM_REGIONS-1:0] RST_NARROW = '0,
   parameter logic [NUM_REGIONS-1:0] RST_IO = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [SEL_W-1:0]       cfg_sel,
   input  logic                   cfg_narrow,
   input  logic                   cfg_io,
   output logic [NUM_REGIONS-1:0] narrow_o,
   output logic [NUM_REGIONS-1:0] io_o
);
   // One configuration slot per region; selectors at or above NUM_REGIONS match no slot.
   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
      logic hit;
      assign hit = cfg_we && (cfg_sel == SEL_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            narrow_o[g] <= RST_NARROW[g];
            io_o[g]     <= RST_IO[g];
         end else if (hit) begin
            narrow_o[g] <= cfg_narrow;
            io_o[g]     <= cfg_io;
         end
      end
   end
endmodule

// File: rtl/csdec_region_dec.sv
module csdec_region_dec #(
   parameter int unsigned NUM_REGIONS = 7,
   parameter int unsigned SEL_W = 3
) (
   input  logic [SEL_W-1:0]       region_bits,
   output logic [NUM_REGIONS-1:0] onehot,
   output logic                   hit
);
   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
      assign onehot[g] = (region_bits == SEL_W'(g));
   end
   assign hit = |onehot;
endmodule

// File: rtl/csdec_seq.sv
module csdec_seq
   import csdec_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned NUM_REGIONS = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req,
   input  logic                   we,
   input  logic [ADDR_W-1:1]      hw_addr,
   input  logic [LANES-1:0]       be,
   input  logic [HALF_W-1:0]      wdata,
   input  logic                   hit,
   input  logic [NUM_REGIONS-1:0] onehot,
   input  logic [NUM_REGIONS-1:0] narrow_vec,
   input  logic [NUM_REGIONS-1:0] io_vec,
   output logic                   ready,
   output logic [HALF_W-1:0]      rdata,
   output logic [ADDR_W-1:0]      ext_addr,
   output logic [HALF_W-1:0]      ext_wdata,
   input  logic [HALF_W-1:0]      ext_rdata,
   output logic [LANES-1:0]       ext_be_n,
   output logic [NUM_REGIONS-1:0] ext_cs_n,
   output logic                   ext_rd_n,
   output logic                   ext_wr_n,
   output logic                   ext_io
);
   seq_st_e st_q, st_d;
   logic                   we_q, narrow_q, io_q;
   logic [ADDR_W-1:1]      addr_q;
   logic [LANES-1:0]       be_q;
   logic [HALF_W-1:0]      wdata_q, rdata_q;
   logic [NUM_REGIONS-1:0] cs_q;
   logic accept, noop, act, hi_lane, split;

   assign accept  = (st_q == ST_IDLE) && req;
   assign noop    = !hit || (be == '0);
   assign act     = (st_q == ST_PH1) || (st_q == ST_PH2);
   assign split   = narrow_q && (be_q == 2'b11);
   assign hi_lane = (st_q == ST_PH2) || (be_q == 2'b10);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (req) st_d = noop ? ST_DONE : ST_PH1;
         ST_PH1:  st_d = split ? ST_PH2 : ST_DONE;
         ST_PH2:  st_d = ST_DONE;
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         we_q     <= 1'b0;
         narrow_q <= 1'b0;
         io_q     <= 1'b0;
         addr_q   <= '0;
         be_q     <= '0;
         wdata_q  <= '0;
         cs_q     <= '0;
         rdata_q  <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            we_q     <= we;
            addr_q   <= hw_addr;
            be_q     <= be;
            wdata_q  <= wdata;
            cs_q     <= noop ? '0 : onehot;
            narrow_q <= |(onehot & narrow_vec);
            io_q     <= |(onehot & io_vec);
            rdata_q  <= '0;
         end else if (act && !we_q) begin
            if (!narrow_q)    rdata_q <= ext_rdata;
            else if (hi_lane) rdata_q[HALF_W-1:BYTE_W] <= ext_rdata[BYTE_W-1:0];
            else              rdata_q[BYTE_W-1:0] <= ext_rdata[BYTE_W-1:0];
         end
      end
   end

   always_comb begin
      if (narrow_q) begin
         ext_addr  = {addr_q, hi_lane};
         ext_wdata = {{BYTE_W{1'b0}}, hi_lane ? wdata_q[HALF_W-1:BYTE_W] : wdata_q[BYTE_W-1:0]};
         ext_be_n  = 2'b10;
      end else begin
         ext_addr  = {addr_q, 1'b0};
         ext_wdata = wdata_q;
         ext_be_n  = ~be_q;
      end
   end

   assign ext_cs_n = act ? ~cs_q : '1;
   assign ext_rd_n = !(act && !we_q);
   assign ext_wr_n = !(act && we_q);
   assign ext_io   = act && io_q;
   assign ready    = (st_q == ST_DONE);
   assign rdata    = rdata_q;

   assert_one_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ext_cs_n));
   assert_ready_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (&ext_cs_n));
   assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_cs_n != '1) |-> (ext_rd_n != ext_wr_n));
   assert_strobe_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_cs_n == '1) |-> (ext_rd_n && ext_wr_n && !ext_io));
   assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);
   assert_split_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PH2) |-> ((ext_addr == $past(ext_addr) + 1'b1) && $stable(ext_cs_n)));
endmodule

// File: rtl/csdec_top.sv
module csdec_top
   import csdec_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned NUM_REGIONS = 7,
   localparam int unsigned SEL_W = $clog2(NUM_REGIONS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [SEL_W-1:0]       cfg_sel,
   input  logic                   cfg_narrow,
   input  logic                   cfg_io,
   input  logic                   cpu_req,
   input  logic                   cpu_we,
   input  logic [ADDR_W-1:1]      cpu_hw_addr,
   input  logic [1:0]             cpu_be,
   input  logic [15:0]            cpu_wdata,
   output logic                   cpu_ready,
   output logic [15:0]            cpu_rdata,
   output logic [ADDR_W-1:0]      ext_addr,
   output logic [15:0]            ext_wdata,
   input  logic [15:0]            ext_rdata,
   output logic [1:0]             ext_be_n,
   output logic [NUM_REGIONS-1:0] ext_cs_n,
   output logic                   ext_rd_n,
   output logic                   ext_wr_n,
   output logic                   ext_io
);
   if (NUM_REGIONS < 2) begin : g_chk_regions
      $error("csdec_top: NUM_REGIONS must be at least 2");
   end
   if (ADDR_W < SEL_W + 2) begin : g_chk_addr
      $error("csdec_top: ADDR_W too small for region field");
   end
   if (HALF_W != 16) begin : g_chk_data
      $error("csdec_top: data path must be 16 bits");
   end

   logic [NUM_REGIONS-1:0] narrow_vec, io_vec, onehot;
   logic                   hit;

   csdec_cfg #(.NUM_REGIONS(NUM_REGIONS), .SEL_W(SEL_W)) cfg_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_narrow(cfg_narrow), .cfg_io(cfg_io),
      .narrow_o(narrow_vec), .io_o(io_vec)
   );

   csdec_region_dec #(.NUM_REGIONS(NUM_REGIONS), .SEL_W(SEL_W)) dec_i (
      .region_bits(cpu_hw_addr[ADDR_W-1 -: SEL_W]), .onehot(onehot), .hit(hit)
   );

   csdec_seq #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS)) seq_i (
      .clk(clk), .rst_n(rst_n), .req(cpu_req), .we(cpu_we),
      .hw_addr(cpu_hw_addr), .be(cpu_be), .wdata(cpu_wdata),
      .hit(hit), .onehot(onehot), .narrow_vec(narrow_vec), .io_vec(io_vec),
      .ready(cpu_ready), .rdata(cpu_rdata),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
      .ext_be_n(ext_be_n), .ext_cs_n(ext_cs_n),
      .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_io(ext_io)
   );
endmodule

// File: tb/csdec_top_tb_top.sv
module csdec_top_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_narrow = 1'b0, cfg_io = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [23:1] cpu_hw_addr = '0;
   logic [1:0]  cpu_be = '0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [15:0] cpu_rdata;
   logic [23:0] ext_addr;
   logic [15:0] ext_wdata, ext_rdata;
   logic [1:0]  ext_be_n;
   logic [6:0]  ext_cs_n;
   logic        ext_rd_n, ext_wr_n, ext_io;

   int n_cmp = 0;
   int n_bad = 0;
   bit model_narrow [8];
   bit model_io [8];

   always #10 clk = ~clk;

   // External device model: read data is a fixed function of the address.
   assign ext_rdata = {ext_addr[7:0] ^ 8'hA5, ext_addr[7:0] ^ 8'h3C};

   csdec_top dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_narrow(cfg_narrow), .cfg_io(cfg_io), .cpu_req(cpu_req),
      .cpu_we(cpu_we), .cpu_hw_addr(cpu_hw_addr), .cpu_be(cpu_be),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
      .ext_be_n(ext_be_n), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
      .ext_wr_n(ext_wr_n), .ext_io(ext_io)
   );

   function automatic logic [15:0] dev_word(input logic [23:0] a);
      return {a[7:0] ^ 8'hA5, a[7:0] ^ 8'h3C};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk({tag, " cs"}, {25'd0, ext_cs_n}, 32'h7F);
      chk({tag, " strobes"}, {30'd0, ext_rd_n, ext_wr_n}, 32'h3);
      chk({tag, " io"}, {31'd0, ext_io}, 32'h0);
   endtask

   task automatic set_cfg(input int r, input bit nar, input bit io);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 3'(r); cfg_narrow = nar; cfg_io = io;
      @(negedge clk);
      cfg_we = 1'b0;
      if (r < 7) begin
         model_narrow[r] = nar;
         model_io[r] = io;
      end
      chk_idle("R3 cfg idle");
   endtask

   task automatic access(input bit w, input logic [23:0] a, input logic [1:0] b,
                         input logic [15:0] d);
      int r;
      bit valid, nar;
      int n;
      logic [23:0] ea [2];
      logic [1:0]  eb [2];
      logic [15:0] ed [2];
      logic [15:0] er, t;
      r = int'(a[23:21]);
      valid = (r < 7) && (b != 2'b00);
      nar = valid && model_narrow[r];
      n = 0;
      er = '0;
      if (valid && !nar) begin
         ea[0] = {a[23:1], 1'b0}; eb[0] = ~b; ed[0] = d; n = 1;
         if (!w) er = dev_word(ea[0]);
      end else if (valid) begin
         if (b[0]) begin
            ea[n] = {a[23:1], 1'b0}; eb[n] = 2'b10; ed[n] = {8'h00, d[7:0]};
            t = dev_word(ea[n]);
            if (!w) er[7:0] = t[7:0];
            n++;
         end
         if (b[1]) begin
            ea[n] = {a[23:1], 1'b1}; eb[n] = 2'b10; ed[n] = {8'h00, d[15:8]};
            t = dev_word(ea[n]);
            if (!w) er[15:8] = t[7:0];
            n++;
         end
      end
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = w; cpu_hw_addr = a[23:1]; cpu_be = b; cpu_wdata = d;
      for (int k = 1; k <= n + 1; k++) begin
         @(negedge clk);
         if (k <= n) begin
            chk("R1 cs during cycle", {25'd0, ext_cs_n}, {25'd0, ~(7'd1 << r)});
            chk("R8 strobes", {30'd0, ext_rd_n, ext_wr_n}, {30'd0, w, ~w});
            chk("R8 no early ready", {31'd0, cpu_ready}, 32'd0);
            chk("R4 type bit", {31'd0, ext_io}, {31'd0, model_io[r]});
            chk(nar ? "R6/R7 addr" : "R5 addr", {8'd0, ext_addr}, {8'd0, ea[k-1]});
            chk(nar ? "R6/R7 be_n" : "R5 be_n", {30'd0, ext_be_n}, {30'd0, eb[k-1]});
            if (w) chk(nar ? "R6/R7 wdata" : "R5 wdata", {16'd0, ext_wdata}, {16'd0, ed[k-1]});
         end else begin
            chk("R8 ready", {31'd0, cpu_ready}, 32'd1);
            chk(!valid ? "R9 rdata" : (nar ? "R6/R7 rdata" : "R5 rdata"),
                {16'd0, cpu_rdata}, {16'd0, er});
            chk_idle("R1 ready idle");
            cpu_req = 1'b0;
         end
      end
      @(negedge clk);
      chk("R8 ready pulse", {31'd0, cpu_ready}, 32'd0);
      chk_idle("R1 after access");
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         model_narrow[i] = 1'b0;
         model_io[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      chk_idle("R2 in reset");
      chk("R2 ready reset", {31'd0, cpu_ready}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R2 after reset");
      // R2/R5: all regions start 16 bits wide
      access(1'b0, {3'd0, 21'h000010}, 2'b11, 16'h0000);
      access(1'b1, {3'd1, 21'h000020}, 2'b01, 16'hBEEF);
      access(1'b0, {3'd2, 21'h000104}, 2'b10, 16'h0000);
      access(1'b0, {3'd3, 21'h000042}, 2'b11, 16'h0000);
      // R3: make region 3 narrow, device type 1
      set_cfg(3, 1'b1, 1'b1);
      access(1'b0, {3'd3, 21'h000042}, 2'b11, 16'h0000);   // R6 split read
      access(1'b1, {3'd3, 21'h000080}, 2'b11, 16'h1234);   // R6 split write
      access(1'b0, {3'd3, 21'h0000A6}, 2'b01, 16'h0000);   // R7 low byte
      access(1'b0, {3'd3, 21'h0000A6}, 2'b10, 16'h0000);   // R7 high byte
      access(1'b1, {3'd3, 21'h0000C8}, 2'b10, 16'hAB00);   // R7 high byte write
      access(1'b1, {3'd3, 21'h0000CA}, 2'b01, 16'h00CD);   // R7 low byte write
      // R9: unmapped region and empty byte enables
      access(1'b0, {3'd7, 21'h000010}, 2'b11, 16'h0000);
      access(1'b1, {3'd7, 21'h000010}, 2'b11, 16'hFFFF);
      access(1'b0, {3'd0, 21'h000010}, 2'b00, 16'h0000);
      // R3: selector 7 stores nothing; region 6 narrow, type 0; region 3 back to wide
      set_cfg(7, 1'b1, 1'b1);
      set_cfg(6, 1'b1, 1'b0);
      set_cfg(3, 1'b0, 1'b1);
      access(1'b0, {3'd3, 21'h000042}, 2'b11, 16'h0000);   // R4 wide with type 1
      access(1'b0, {3'd6, 21'h1FFFFE}, 2'b11, 16'h0000);   // R6 top of space
      access(1'b1, {3'd5, 21'h000300}, 2'b11, 16'hCAFE);   // R5 full write
      access(1'b0, {3'd4, 21'h000010}, 2'b11, 16'h0000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule